// File: doc/BRIEF.md
# Transmit Buffer Descriptor Engine

This block serves the transmit side of an Ethernet controller. Software builds a ring of 8-byte buffer descriptors in memory and hands each one to the hardware by setting its ready bit. It then issues a transmit-demand pulse. The engine walks the ring from its current pointer. For each descriptor it fetches the buffer in 32-bit words and streams the bytes out on a valid/ready byte interface. It then writes the descriptor back with the ready bit cleared and moves to the next descriptor.

Several descriptors can be chained into one frame, and the frame ends at the descriptor that carries the last flag. The frame length is capped by a hard limit. Bytes beyond that limit are dropped and a babble event is pulsed. Each walk is also bounded in the number of descriptors it may process, so a ring that software keeps full cannot hold the engine forever. Single-cycle event pulses feed a separate interrupt controller.

Top module: `tx_bd_engine`

## Requirements
- R1: A descriptor at pointer P is two big-endian 32-bit words. The word at P holds the flags in bits 31:16 and the byte length in bits 15:0. The word at P+4 holds the buffer byte address. The ready flag is word bit 31, wrap is bit 29 and last is bit 27. A memory request holds its address and direction until it is acknowledged.
- R2: A demand pulse starts a walk only while `en_i` is high. A demand that arrives while idle and disabled is dropped: no memory request, no byte and no busy.
- R3: A walk stops at the first descriptor whose ready bit is clear. That descriptor is not written back.
- R4: A walk processes at most MAX_DESC descriptors. Ready descriptors that remain stay untouched and are processed by the next demand.
- R5: Buffer bytes are emitted in address order, starting at any byte alignment, from 32-bit words read most significant byte first. Data and last stay stable while valid is high and ready is low.
- R6: `tx_last_o` is high only with the final emitted byte of a descriptor whose last flag is set.
- R7: The running frame length plus a descriptor length never exceeds MAX_FRAME. Only the bytes up to MAX_FRAME are emitted, and `ev_babt_o` pulses for that descriptor. A last descriptor resets the running length to zero.
- R8: Each processed descriptor is rewritten at P with the ready bit cleared and the other flags and the length unchanged. `ev_txb_o` pulses once per descriptor, and `ev_txf_o` pulses with it for a last descriptor.
- R9: The next pointer is the ring base when the wrap flag is set, and P+8 otherwise.
- R10: A base write stores `base_i` with bits 1:0 forced to zero and reloads the current pointer with that value.
- R11: `busy_o` stays high from walk start to walk end. A demand during a walk causes exactly one further walk after it.
- R12: After reset, busy, stream valid, memory request and all events are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Global transmit enable |
| demand_i | input | 1 | Transmit-demand pulse |
| base_wr_i | input | 1 | Load ring base and pointer |
| base_i | input | 32 | Ring base address |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Word-aligned byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request completed this cycle |
| mem_rdata_i | input | 32 | Read data, valid with ack |
| tx_data_o | output | 8 | Stream byte |
| tx_valid_o | output | 1 | Stream byte valid |
| tx_ready_i | input | 1 | Sink accepts byte |
| tx_last_o | output | 1 | Final byte of a frame |
| busy_o | output | 1 | Walk in progress |
| ev_txb_o | output | 1 | Descriptor done pulse |
| ev_txf_o | output | 1 | Frame done pulse |
| ev_babt_o | output | 1 | Frame truncated pulse |

## Verification
A corrupted byte pointer or remaining count shows up within one stream beat: a wrong byte, a missing or extra byte, or a misplaced last flag in the emitted stream. A wrong ring pointer or running frame length shows up at the next descriptor fetch, either as a wrong fetch address or as wrong truncation. A faulty write-back is visible in memory as soon as the walk ends, because the bench compares the whole memory against an independent walk model after every scenario. Event counts and busy rising edges are compared per walk, so an extra or lost pulse is caught in the same scenario.

// File: rtl/tx_bd_pkg.sv
package tx_bd_pkg;
  typedef enum logic [2:0] {S_IDLE, S_RD0, S_RD1, S_RDW, S_EMIT, S_WB} st_e;
  localparam int FLAG_RDY = 15;
  localparam int FLAG_WRP = 13;
  localparam int FLAG_LST = 11;
endpackage

// File: rtl/tx_trunc_calc.sv
module tx_trunc_calc #(
  parameter int LEN_W     = 16,
  parameter int MAX_FRAME = 2032
) (
  input  logic [LEN_W-1:0] len_i,
  input  logic [LEN_W-1:0] flen_i,
  output logic [LEN_W-1:0] take_o,
  output logic             trunc_o
);
  logic [LEN_W-1:0] room;
  assign room    = LEN_W'(MAX_FRAME) - flen_i;
  assign trunc_o = len_i > room;
  assign take_o  = trunc_o ? room : len_i;
endmodule

// File: rtl/tx_byte_pick.sv
module tx_byte_pick (
  input  logic [31:0] word_i,
  input  logic [1:0]  off_i,
  output logic [7:0]  byte_o
);
  // lowest address sits in the most significant lane
  always_comb begin
    byte_o = '0;
    for (int i = 0; i < 4; i++)
      if (off_i == 2'(i)) byte_o = word_i[8*(3-i) +: 8];
  end
endmodule

// File: rtl/tx_bd_engine.sv
module tx_bd_engine #(
  parameter int AW        = 32,
  parameter int LEN_W     = 16,
  parameter int MAX_FRAME = 2032,
  parameter int MAX_DESC  = 1024
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          demand_i,
  input  logic          base_wr_i,
  input  logic [AW-1:0] base_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [31:0]   mem_rdata_i,
  output logic [7:0]    tx_data_o,
  output logic          tx_valid_o,
  input  logic          tx_ready_i,
  output logic          tx_last_o,
  output logic          busy_o,
  output logic          ev_txb_o,
  output logic          ev_txf_o,
  output logic          ev_babt_o
);
  import tx_bd_pkg::*;

  localparam int CNT_W = $clog2(MAX_DESC + 1);

  st_e              state_q;
  logic [AW-1:0]    base_q, cur_q, bptr_q;
  logic [15:0]      flags_q;
  logic [LEN_W-1:0] len_q, take_q, rem_q, flen_q;
  logic             trunc_q, pend_q;
  logic [31:0]      word_q;
  logic [CNT_W-1:0] cnt_q;
  logic             txb_q, txf_q, babt_q;

  logic [LEN_W-1:0] take_c;
  logic             trunc_c;
  logic [7:0]       byte_c;
  logic             start, beat, acked;

  tx_trunc_calc #(.LEN_W(LEN_W), .MAX_FRAME(MAX_FRAME)) u_trunc (
    .len_i  (mem_rdata_i[LEN_W-1:0]),
    .flen_i (flen_q),
    .take_o (take_c),
    .trunc_o(trunc_c)
  );

  tx_byte_pick u_pick (
    .word_i(word_q),
    .off_i (bptr_q[1:0]),
    .byte_o(byte_c)
  );

  assign start = (state_q == S_IDLE) && (demand_i || pend_q) && en_i;
  assign beat  = (state_q == S_EMIT) && tx_ready_i;
  assign acked = mem_req_o && mem_ack_i;

  always_comb begin
    mem_req_o  = state_q inside {S_RD0, S_RD1, S_RDW, S_WB};
    mem_we_o   = state_q == S_WB;
    mem_addr_o = cur_q;
    if (state_q == S_RD1) mem_addr_o = cur_q + AW'(4);
    if (state_q == S_RDW) mem_addr_o = {bptr_q[AW-1:2], 2'b00};
  end

  assign mem_wdata_o = {flags_q & ~(16'h1 << FLAG_RDY), 16'(len_q)};
  assign tx_valid_o  = state_q == S_EMIT;
  assign tx_data_o   = byte_c;
  assign tx_last_o   = tx_valid_o && flags_q[FLAG_LST] && (rem_q == LEN_W'(1));
  assign busy_o      = state_q != S_IDLE;
  assign ev_txb_o    = txb_q;
  assign ev_txf_o    = txf_q;
  assign ev_babt_o   = babt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      base_q  <= '0;
      cur_q   <= '0;
      bptr_q  <= '0;
      flags_q <= '0;
      len_q   <= '0;
      take_q  <= '0;
      rem_q   <= '0;
      flen_q  <= '0;
      trunc_q <= 1'b0;
      pend_q  <= 1'b0;
      word_q  <= '0;
      cnt_q   <= '0;
      txb_q   <= 1'b0;
      txf_q   <= 1'b0;
      babt_q  <= 1'b0;
    end else begin
      txb_q  <= 1'b0;
      txf_q  <= 1'b0;
      babt_q <= 1'b0;
      if (state_q != S_IDLE && demand_i) pend_q <= 1'b1;
      case (state_q)
        S_IDLE: begin
          pend_q <= 1'b0;
          if (start) begin
            cnt_q   <= '0;
            state_q <= S_RD0;
          end
        end
        S_RD0: if (acked) begin
          flags_q <= mem_rdata_i[31:16];
          len_q   <= mem_rdata_i[LEN_W-1:0];
          take_q  <= take_c;
          trunc_q <= trunc_c;
          state_q <= mem_rdata_i[16+FLAG_RDY] ? S_RD1 : S_IDLE;
        end
        S_RD1: if (acked) begin
          bptr_q  <= mem_rdata_i[AW-1:0];
          rem_q   <= take_q;
          state_q <= (take_q == '0) ? S_WB : S_RDW;
        end
        S_RDW: if (acked) begin
          word_q  <= mem_rdata_i;
          state_q <= S_EMIT;
        end
        S_EMIT: if (beat) begin
          bptr_q <= bptr_q + AW'(1);
          rem_q  <= rem_q - LEN_W'(1);
          if (rem_q == LEN_W'(1))    state_q <= S_WB;
          else if (&bptr_q[1:0])     state_q <= S_RDW;
        end
        S_WB: if (acked) begin
          txb_q  <= 1'b1;
          txf_q  <= flags_q[FLAG_LST];
          babt_q <= trunc_q;
          flen_q <= flags_q[FLAG_LST] ? '0 : flen_q + take_q;
          cur_q  <= flags_q[FLAG_WRP] ? base_q : cur_q + AW'(8);
          cnt_q  <= cnt_q + CNT_W'(1);
          state_q <= (cnt_q == CNT_W'(MAX_DESC - 1)) ? S_IDLE : S_RD0;
        end
        default: state_q <= S_IDLE;
      endcase
      if (base_wr_i) begin
        base_q <= {base_i[AW-1:2], 2'b00};
        cur_q  <= {base_i[AW-1:2], 2'b00};
      end
    end
  end
endmodule

// File: rtl/tx_bd_engine_chk.sv
module tx_bd_engine_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [31:0]   mem_wdata_o,
  input logic          mem_ack_i,
  input logic [7:0]    tx_data_o,
  input logic          tx_valid_o,
  input logic          tx_ready_i,
  input logic          tx_last_o,
  input logic          busy_o,
  input logic          ev_txb_o,
  input logic          ev_txf_o,
  input logic          ev_babt_o
);
  p_req_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  p_no_start_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !en_i |=> !busy_o);

  p_stream_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o));

  p_last_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_last_o |-> tx_valid_o);

  p_wb_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> !mem_wdata_o[31] && (mem_addr_o[2:0] == 3'b000));

  p_ev_pair_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_txf_o || ev_babt_o) |-> ev_txb_o);

  p_txb_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_txb_o |=> !ev_txb_o);

  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && !tx_valid_o);
endmodule

bind tx_bd_engine tx_bd_engine_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
  .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
  .tx_data_o(tx_data_o), .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i),
  .tx_last_o(tx_last_o), .busy_o(busy_o),
  .ev_txb_o(ev_txb_o), .ev_txf_o(ev_txf_o), .ev_babt_o(ev_babt_o)
);

// File: tb/tb_tx_bd_engine.sv
module tb_tx_bd_engine;
  localparam int MAXF = 40;
  localparam int MAXD = 4;
  localparam logic [15:0] RDY = 16'h8000, WRP = 16'h2000, LST = 16'h0800;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        en = 1'b0, demand = 1'b0, base_wr = 1'b0;
  logic [31:0] base = '0;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_ready = 1'b0, tx_last, busy;
  logic        ev_txb, ev_txf, ev_babt;

  always #2 clk = ~clk;

  tx_bd_engine #(.MAX_FRAME(MAXF), .MAX_DESC(MAXD)) dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .demand_i(demand),
    .base_wr_i(base_wr), .base_i(base),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
    .tx_last_o(tx_last), .busy_o(busy),
    .ev_txb_o(ev_txb), .ev_txf_o(ev_txf), .ev_babt_o(ev_babt)
  );

  logic [7:0] mem_b [1024];
  logic [7:0] exp_b [1024];
  logic [7:0] got_d[$], exp_d[$];
  bit         got_l[$], exp_l[$];
  int checks = 0, errors = 0;
  int n_txb = 0, n_txf = 0, n_babt = 0, n_rise = 0, n_req = 0;
  int e_txb = 0, e_txf = 0, e_babt = 0;
  int lat = 0, wcnt = 0, cyc = 0;
  bit slow_sink = 1'b0, cap_arm = 1'b0, busy_prev = 1'b0, req_prev = 1'b0;
  logic [31:0] cap_addr = '0;
  int m_ptr = 0, m_base = 0, m_flen = 0;

  function automatic logic [31:0] rd_mem(int a);
    return {mem_b[a & 1023], mem_b[(a+1) & 1023], mem_b[(a+2) & 1023], mem_b[(a+3) & 1023]};
  endfunction
  function automatic logic [31:0] rd_exp(int a);
    return {exp_b[a & 1023], exp_b[(a+1) & 1023], exp_b[(a+2) & 1023], exp_b[(a+3) & 1023]};
  endfunction

  task automatic wr_both(int a, logic [31:0] v);
    for (int i = 0; i < 4; i++) begin
      mem_b[(a+i) & 1023] = v[8*(3-i) +: 8];
      exp_b[(a+i) & 1023] = v[8*(3-i) +: 8];
    end
  endtask
  task automatic wr_exp(int a, logic [31:0] v);
    for (int i = 0; i < 4; i++) exp_b[(a+i) & 1023] = v[8*(3-i) +: 8];
  endtask
  task automatic put_desc(int a, logic [15:0] fl, int len, int buf_a);
    wr_both(a, {fl, 16'(len)});
    wr_both(a + 4, 32'(buf_a));
  endtask

  // independent ring walk from the requirements
  task automatic model_walk();
    int n = 0;
    while (n < MAXD) begin
      logic [31:0] w0 = rd_exp(m_ptr);
      int len, ba, room, take;
      if (!w0[31]) break;
      len = int'(w0[15:0]);
      ba = int'(rd_exp(m_ptr + 4));
      room = MAXF - m_flen;
      take = (len > room) ? room : len;
      if (len > room) e_babt++;
      for (int i = 0; i < take; i++) begin
        exp_d.push_back(exp_b[(ba + i) & 1023]);
        exp_l.push_back(w0[27] && (i == take - 1));
      end
      m_flen = w0[27] ? 0 : m_flen + take;
      if (w0[27]) e_txf++;
      e_txb++;
      wr_exp(m_ptr, {w0[31:16] & ~RDY, w0[15:0]});
      m_ptr = w0[29] ? m_base : m_ptr + 8;
      n++;
    end
  endtask

  task automatic chk(bit ok, string rq, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, expv);
    end
  endtask

  task automatic cmp_walk(string rq);
    int mism = 0, mm = 0;
    chk(got_d.size() == exp_d.size(), rq, "byte count", got_d.size(), exp_d.size());
    for (int i = 0; i < got_d.size() && i < exp_d.size(); i++)
      if (got_d[i] !== exp_d[i] || got_l[i] !== exp_l[i]) mism++;
    chk(mism == 0, rq, "byte/last mismatches", mism, 0);
    chk(n_txb == e_txb, rq, "txb events", n_txb, e_txb);
    chk(n_txf == e_txf, rq, "txf events", n_txf, e_txf);
    chk(n_babt == e_babt, rq, "babt events", n_babt, e_babt);
    for (int i = 0; i < 1024; i++) if (mem_b[i] !== exp_b[i]) mm++;
    chk(mm == 0, rq, "memory byte mismatches", mm, 0);
    got_d.delete(); got_l.delete(); exp_d.delete(); exp_l.delete();
    n_txb = 0; n_txf = 0; n_babt = 0; e_txb = 0; e_txf = 0; e_babt = 0;
    n_rise = 0; n_req = 0;
  endtask

  task automatic set_base(int a);
    @(negedge clk); base = 32'(a); base_wr = 1'b1;
    @(negedge clk); base_wr = 1'b0;
    m_base = a & ~3; m_ptr = m_base;
  endtask
  task automatic pulse_demand();
    @(negedge clk); demand = 1'b1;
    @(negedge clk); demand = 1'b0;
  endtask
  task automatic wait_idle();
    int q = 0;
    while (q < 4) begin
      @(negedge clk);
      if (busy) q = 0; else q++;
    end
  endtask

  // memory slave, stream sink and observers
  always @(negedge clk) begin
    cyc++;
    if (mem_req && !req_prev) n_req++;
    if (mem_req && !req_prev && cap_arm) begin cap_addr = mem_addr; cap_arm = 1'b0; end
    req_prev = mem_req;
    if (mem_req) begin
      if (wcnt >= lat) begin
        mem_ack = 1'b1; wcnt = 0;
        if (mem_we)
          for (int i = 0; i < 4; i++) mem_b[(int'(mem_addr) + i) & 1023] = mem_wdata[8*(3-i) +: 8];
        else mem_rdata = rd_mem(int'(mem_addr));
      end else begin
        mem_ack = 1'b0; wcnt++;
      end
    end else begin
      mem_ack = 1'b0; wcnt = 0;
    end
    tx_ready = slow_sink ? (cyc % 3 != 0) : 1'b1;
    if (tx_valid && tx_ready) begin got_d.push_back(tx_data); got_l.push_back(tx_last); end
    n_txb += int'(ev_txb); n_txf += int'(ev_txf); n_babt += int'(ev_babt);
    if (busy && !busy_prev) n_rise++;
    busy_prev = busy;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R11", "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin mem_b[i] = 8'(i * 7 + 3); exp_b[i] = mem_b[i]; end
    repeat (3) @(negedge clk);
    chk(!busy && !tx_valid && !mem_req, "R12", "busy/valid/req after reset", int'({busy, tx_valid, mem_req}), 0);
    chk(!ev_txb && !ev_txf && !ev_babt, "R12", "events after reset", int'({ev_txb, ev_txf, ev_babt}), 0);
    rst_n = 1'b1; en = 1'b1;
    @(negedge clk);

    // single unaligned descriptor
    set_base(32'h100);
    put_desc(32'h100, RDY | LST, 5, 32'h201);
    put_desc(32'h108, 16'h0, 0, 0);
    model_walk(); pulse_demand(); wait_idle();
    chk(n_rise == 1, "R11", "busy rises for one walk", n_rise, 1);
    cmp_walk("R1 R5 R6 R8 single");

    // gather with latency and backpressure, stop at non-ready
    lat = 2; slow_sink = 1'b1;
    put_desc(32'h108, RDY, 3, 32'h213);
    put_desc(32'h110, RDY, 6, 32'h222);
    put_desc(32'h118, RDY | LST, 2, 32'h230);
    put_desc(32'h120, 16'h0, 0, 0);
    model_walk(); pulse_demand(); wait_idle();
    cmp_walk("R3 R5 gather");
    lat = 0; slow_sink = 1'b0;

    // truncation at the frame cap
    put_desc(32'h120, RDY, 30, 32'h240);
    put_desc(32'h128, RDY | LST, 30, 32'h260);
    put_desc(32'h130, RDY | LST, 12, 32'h280);
    put_desc(32'h138, 16'h0, 0, 0);
    model_walk(); pulse_demand(); wait_idle();
    chk(n_babt == 1, "R7", "one babble pulse", n_babt, 1);
    cmp_walk("R7 truncation");

    // descriptor limit per walk
    for (int k = 0; k < 6; k++) put_desc(32'h138 + 8 * k, RDY | LST, 1, 32'h2a0 + k);
    put_desc(32'h168, 16'h0, 0, 0);
    model_walk(); pulse_demand(); wait_idle();
    chk(n_txb == MAXD, "R4", "descriptors in capped walk", n_txb, MAXD);
    cmp_walk("R4 limit");
    model_walk(); pulse_demand(); wait_idle();
    cmp_walk("R4 remainder");

    // wrap back to base
    put_desc(32'h168, RDY | LST | WRP, 2, 32'h2c0);
    model_walk(); pulse_demand(); wait_idle();
    cmp_walk("R9 wrap");
    put_desc(32'h100, RDY | LST, 3, 32'h2d0);
    put_desc(32'h108, 16'h0, 0, 0);
    cap_arm = 1'b1;
    model_walk(); pulse_demand(); wait_idle();
    chk(cap_addr == 32'h100, "R9", "fetch after wrap", int'(cap_addr), 32'h100);
    cmp_walk("R9 after wrap");

    // base write masks low bits
    set_base(32'h1c3);
    put_desc(32'h1c0, RDY | LST, 4, 32'h2e0);
    put_desc(32'h1c8, 16'h0, 0, 0);
    cap_arm = 1'b1;
    model_walk(); pulse_demand(); wait_idle();
    chk(cap_addr == 32'h1c0, "R10", "first fetch address", int'(cap_addr), 32'h1c0);
    cmp_walk("R10 base");

    // disabled demand ignored
    en = 1'b0;
    put_desc(32'h1c8, RDY | LST, 2, 32'h2f0);
    put_desc(32'h1d0, 16'h0, 0, 0);
    pulse_demand(); repeat (20) @(negedge clk);
    chk(n_rise == 0 && n_req == 0, "R2", "activity while disabled", n_rise + n_req, 0);
    cmp_walk("R2 disabled");
    en = 1'b1;
    model_walk(); pulse_demand(); wait_idle();
    cmp_walk("R2 enabled");

    // demand during a walk
    put_desc(32'h1d0, RDY | LST, 8, 32'h300);
    put_desc(32'h1d8, 16'h0, 0, 0);
    model_walk(); model_walk();
    pulse_demand(); repeat (3) @(negedge clk);
    chk(busy == 1'b1, "R11", "busy mid walk", int'(busy), 1);
    pulse_demand(); wait_idle();
    chk(n_rise == 2, "R11", "walks after busy demand", n_rise, 2);
    cmp_walk("R11 pending");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule